// File: doc/BRIEF.md
# Serial EEPROM Write-and-Verify Sequencer

This block runs a serial EEPROM through a full write-then-verify pass with no processor in the loop. After a start pulse it clears the device's protection bits, fills an address region with a known pattern in bursts, and waits for each internal write cycle to finish by polling the device's busy flag. It then reads the region back one byte at a time and compares each byte with the value it wrote, where the value is the low byte of the address. It reports completion, a sticky error, the first failing address and the address it is working on.

The block does not shift bits. It hands whole bytes to an external SPI byte engine and takes one received byte back for every byte it sends. Transmit is a valid/ready stream. The sequencer raises `spi_tx_valid` with a byte and holds both the valid and the byte unchanged until the engine raises `spi_tx_ready` in the same cycle. Only one byte is in flight at a time. After a byte is accepted the sequencer drops valid and waits for a one-cycle `spi_rx_valid` pulse, which carries the byte clocked in during that transfer. It has no receive back-pressure, so it accepts the pulse in any cycle. Several devices can share the bus, each with its own active-low select. `dev_sel`, sampled at start, picks the device for the whole pass.

Top module: `eeprom_wv_seq`

## Requirements
- R1: After reset all select lines are high, `spi_tx_valid` is low, and `done`, `error` and `timed_out` are low.
- R2: When `spi_tx_valid` is high and `spi_tx_ready` is low, the next cycle still has `spi_tx_valid` high with `spi_tx_data` unchanged. No new byte is offered between an accepted byte and its `spi_rx_valid` pulse.
- R3: A pass opens with a write-enable instruction (0x06) and then a status-write instruction (0x01) whose data byte is 0x00, which clears every protection bit.
- R4: Each burst is a write-enable instruction followed by a write instruction. The write instruction is opcode 0x02 with address bit 8 placed in opcode bit 3, then the low address byte, then up to BURST_LEN data bytes. Each data byte equals the low byte of its own address. Select stays low from the opcode through the last data byte.
- R5: After the status write and after every burst, the block sends the status-read instruction (0x05) and one dummy byte (0xFF). Bit 0 of the returned status is the busy flag. While that bit is 1, the block repeats the poll.
- R6: Bursts start at BASE_ADDR and advance by BURST_LEN. Together they write every address from BASE_ADDR through LAST_ADDR exactly once, and the last burst is shortened where the region ends.
- R7: For each address from BASE_ADDR through LAST_ADDR, the read phase sends one read instruction. The read instruction is opcode 0x03 with address bit 8 in opcode bit 3, then the low address byte, then a dummy 0xFF. The byte returned for the dummy is compared with the low address byte.
- R8: Select goes low before each instruction's first byte and stays low through its last byte. It is high for at least one cycle between instructions. Only the select line chosen by `dev_sel` at start ever goes low, and no byte is offered while every select is high.
- R9: A readback mismatch sets `error`, which stays set until the next start. `fail_addr` holds the first mismatching address. Reading carries on to the end of the region.
- R10: `done` rises once the last readback byte has been judged, or on an abort. It stays high until a new start, and a new start clears `done`, `error` and `timed_out`.
- R11: If POLL_LIMIT status polls in a row report busy, the pass aborts with `error`, `timed_out` and `done` set, and no further instruction is sent.
- R12: `progress` shows the address the sequencer is working on. It equals LAST_ADDR when a pass that was not aborted completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass; honoured when idle or done |
| dev_sel | input | DEV_W | Index of the device to exercise, sampled at start |
| spi_tx_valid | output | 1 | Byte offered to the SPI engine |
| spi_tx_ready | input | 1 | SPI engine accepts the offered byte |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_rx_valid | input | 1 | One-cycle pulse: transfer of the accepted byte finished |
| spi_rx_data | input | 8 | Byte shifted in during that transfer |
| cs_n | output | NUM_DEV | Active-low select, one per device |
| done | output | 1 | Pass finished or aborted |
| error | output | 1 | Sticky mismatch or timeout flag |
| timed_out | output | 1 | Busy poll exceeded its limit |
| fail_addr | output | ADDR_W | First address that read back wrong |
| progress | output | ADDR_W | Address currently being processed |

## Verification
Two outcomes can land in the same clock edge: a mismatch on the last address sets `error` at the edge that also raises `done`. The bench corrupts only the final address in its memory model. It then checks that `error` is already high in the first cycle where `done` is seen, and that `fail_addr` names the last address. The bench also starts a pass right after a timeout abort, so that the restart has to clear the flags the abort set.

// File: rtl/eev_pkg.sv
package eev_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] SR_OPEN   = 8'h00;
  localparam int         BUSY_BIT  = 0;
  localparam int         PAGE_POS  = 3;

  typedef enum logic [2:0] {
    PH_WEN_INIT, PH_SRW, PH_POLL, PH_WEN, PH_BURST, PH_CHECK
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT, ST_GAP, ST_DONE
  } state_t;
endpackage

// File: rtl/eev_cmd_gen.sv
module eev_cmd_gen
  import eev_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int IDX_W     = 5,
  parameter int BURST_LEN = 16,
  parameter int LAST_ADDR = 111
) (
  input  phase_t            phase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        byte_o,
  output logic [IDX_W-1:0]  last_idx
);
  logic [ADDR_W:0]   remain;
  logic [IDX_W-1:0]  burst_n;
  logic [7:0]        page_op;
  logic [ADDR_W-1:0] data_addr;

  always_comb begin
    remain    = (ADDR_W+1)'(LAST_ADDR) - {1'b0, addr};
    if (remain >= (ADDR_W+1)'(BURST_LEN - 1)) burst_n = IDX_W'(BURST_LEN);
    else                                      burst_n = IDX_W'(remain) + 1'b1;
    page_op   = 8'((addr >> 8) << PAGE_POS);
    data_addr = addr + ADDR_W'(idx) - ADDR_W'(2);
    byte_o    = FILL_BYTE;
    last_idx  = '0;
    unique case (phase)
      PH_WEN_INIT, PH_WEN: begin
        byte_o   = OP_WREN;
        last_idx = '0;
      end
      PH_SRW: begin
        byte_o   = (idx == '0) ? OP_WRSR : SR_OPEN;
        last_idx = IDX_W'(1);
      end
      PH_POLL: begin
        byte_o   = (idx == '0) ? OP_RDSR : FILL_BYTE;
        last_idx = IDX_W'(1);
      end
      PH_BURST: begin
        if (idx == '0)              byte_o = OP_WRITE | page_op;
        else if (idx == IDX_W'(1))  byte_o = addr[7:0];
        else                        byte_o = data_addr[7:0];
        last_idx = burst_n + IDX_W'(1);
      end
      PH_CHECK: begin
        if (idx == '0)              byte_o = OP_READ | page_op;
        else if (idx == IDX_W'(1))  byte_o = addr[7:0];
        else                        byte_o = FILL_BYTE;
        last_idx = IDX_W'(2);
      end
      default: begin
        byte_o   = FILL_BYTE;
        last_idx = '0;
      end
    endcase
  end
endmodule

// File: rtl/eev_poll_timer.sv
module eev_poll_timer #(
  parameter int POLL_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic busy_seen,
  output logic expired
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    cnt <= '0;
    else if (clear)                                cnt <= '0;
    else if (busy_seen && cnt != CNT_W'(POLL_LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired = busy_seen && (cnt == CNT_W'(POLL_LIMIT - 1));

  AST_POLL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(POLL_LIMIT)) |=> (cnt == '0)); // R11
endmodule

// File: rtl/eev_sel_decode.sv
module eev_sel_decode #(
  parameter int NUM_DEV = 2,
  parameter int DEV_W   = 1
) (
  input  logic [DEV_W-1:0]   dev,
  input  logic               active,
  output logic [NUM_DEV-1:0] cs_n
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
    assign cs_n[g] = !(active && (dev == DEV_W'(g)));
  end
endmodule

// File: rtl/eeprom_wv_seq.sv
module eeprom_wv_seq
  import eev_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int NUM_DEV    = 2,
  parameter int BURST_LEN  = 16,
  parameter int BASE_ADDR  = 0,
  parameter int LAST_ADDR  = 111,
  parameter int POLL_LIMIT = 64,
  localparam int DEV_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DEV_W-1:0]   dev_sel,
  output logic               spi_tx_valid,
  input  logic               spi_tx_ready,
  output logic [7:0]         spi_tx_data,
  input  logic               spi_rx_valid,
  input  logic [7:0]         spi_rx_data,
  output logic [NUM_DEV-1:0] cs_n,
  output logic               done,
  output logic               error,
  output logic               timed_out,
  output logic [ADDR_W-1:0]  fail_addr,
  output logic [ADDR_W-1:0]  progress
);
  localparam int IDX_W = $clog2(BURST_LEN + 2);

  state_t            state;
  phase_t            phase;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr;
  logic [DEV_W-1:0]  dev_q;
  logic              fill_done;
  logic              fail_seen;
  logic [7:0]        cur_byte;
  logic [IDX_W-1:0]  last_idx;
  logic              byte_back;
  logic              instr_end;
  logic              busy_seen;
  logic              poll_expired;
  logic              poll_clear;
  logic [ADDR_W:0]   next_base;
  logic              region_end;

  eev_cmd_gen #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BURST_LEN(BURST_LEN), .LAST_ADDR(LAST_ADDR)
  ) u_cmd (
    .phase(phase), .idx(idx), .addr(addr), .byte_o(cur_byte), .last_idx(last_idx)
  );

  assign byte_back  = (state == ST_WAIT) && spi_rx_valid;
  assign instr_end  = byte_back && (idx == last_idx);
  assign busy_seen  = instr_end && (phase == PH_POLL) && spi_rx_data[BUSY_BIT];
  assign poll_clear = (phase != PH_POLL) || (state == ST_IDLE) || (state == ST_DONE);
  assign next_base  = {1'b0, addr} + (ADDR_W+1)'(BURST_LEN);
  assign region_end = next_base > (ADDR_W+1)'(LAST_ADDR);

  eev_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear),
    .busy_seen(busy_seen), .expired(poll_expired)
  );

  eev_sel_decode #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_sel (
    .dev(dev_q),
    .active((state == ST_SEND) || (state == ST_WAIT)),
    .cs_n(cs_n)
  );

  assign spi_tx_valid = (state == ST_SEND);
  assign spi_tx_data  = cur_byte;
  assign progress     = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_WEN_INIT;
      idx       <= '0;
      addr      <= ADDR_W'(BASE_ADDR);
      dev_q     <= '0;
      fill_done <= 1'b0;
      fail_seen <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      timed_out <= 1'b0;
      fail_addr <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state     <= ST_SEND;
            phase     <= PH_WEN_INIT;
            idx       <= '0;
            addr      <= ADDR_W'(BASE_ADDR);
            dev_q     <= dev_sel;
            fill_done <= 1'b0;
            fail_seen <= 1'b0;
            done      <= 1'b0;
            error     <= 1'b0;
            timed_out <= 1'b0;
            fail_addr <= '0;
          end
        end
        ST_SEND: if (spi_tx_ready) state <= ST_WAIT;
        ST_GAP:  state <= ST_SEND;
        ST_WAIT: begin
          if (byte_back && !instr_end) begin
            idx   <= idx + 1'b1;
            state <= ST_SEND;
          end else if (instr_end) begin
            idx   <= '0;
            state <= ST_GAP;
            unique case (phase)
              PH_WEN_INIT: phase <= PH_SRW;
              PH_SRW:      phase <= PH_POLL;
              PH_WEN:      phase <= PH_BURST;
              PH_BURST: begin
                phase <= PH_POLL;
                if (region_end) begin
                  fill_done <= 1'b1;
                  addr      <= ADDR_W'(BASE_ADDR);
                end else begin
                  addr <= next_base[ADDR_W-1:0];
                end
              end
              PH_POLL: begin
                if (spi_rx_data[BUSY_BIT]) begin
                  if (poll_expired) begin
                    state     <= ST_DONE;
                    done      <= 1'b1;
                    error     <= 1'b1;
                    timed_out <= 1'b1;
                  end
                end else begin
                  phase <= fill_done ? PH_CHECK : PH_WEN;
                end
              end
              PH_CHECK: begin
                if (spi_rx_data != addr[7:0]) begin
                  error <= 1'b1;
                  if (!fail_seen) begin
                    fail_seen <= 1'b1;
                    fail_addr <= addr;
                  end
                end
                if (addr == ADDR_W'(LAST_ADDR)) begin
                  state <= ST_DONE;
                  done  <= 1'b1;
                end else begin
                  addr <= addr + 1'b1;
                end
              end
              default: phase <= PH_WEN_INIT;
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_valid && !spi_tx_ready) |=> (spi_tx_valid && $stable(spi_tx_data))); // R2
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R8
  AST_BYTE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> !(&cs_n)); // R8
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10
  AST_TIMEOUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> (error && done)); // R11
endmodule

// File: tb/tb_eeprom_wv_seq.sv
module tb_eeprom_wv_seq;
  localparam int BASE  = 200;
  localparam int LAST  = 311;
  localparam int LIMIT = 8;
  localparam int NREG  = LAST - BASE + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [0:0] dev_sel = 1'b0;
  logic       spi_tx_valid;
  logic       spi_tx_ready = 1'b0;
  logic [7:0] spi_tx_data;
  logic       spi_rx_valid = 1'b0;
  logic [7:0] spi_rx_data = 8'h00;
  logic [1:0] cs_n;
  logic       done, error, timed_out;
  logic [8:0] fail_addr, progress;

  always #10 clk = ~clk;

  eeprom_wv_seq #(
    .ADDR_W(9), .NUM_DEV(2), .BURST_LEN(16),
    .BASE_ADDR(BASE), .LAST_ADDR(LAST), .POLL_LIMIT(LIMIT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel),
    .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready), .spi_tx_data(spi_tx_data),
    .spi_rx_valid(spi_rx_valid), .spi_rx_data(spi_rx_data),
    .cs_n(cs_n), .done(done), .error(error), .timed_out(timed_out),
    .fail_addr(fail_addr), .progress(progress)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // memory and protocol model
  logic [7:0] mem [0:1][0:511];
  logic       wel [0:1];
  logic [7:0] sr [0:1];
  int   idx_m = 0, cur_dev = 0, d_m = 0, wip_cnt = 0, busy_polls = 0, corrupt = -1;
  logic [7:0] op_m = 8'h00, b_m, resp_m;
  logic [8:0] a_m = '0;
  logic in_txn = 1'b0, outstanding = 1'b0, prev_hold = 1'b0;
  logic [7:0] prev_data = 8'h00;
  logic [1:0] cs_seen = 2'b00;
  int n_wren, n_wrsr, n_wrsr_bad, n_rdsr, n_bursts, n_burst_bad, n_nowel;
  int n_wr_hi, n_rd_hi, n_rd, n_sel_err, n_proto_bad, n_hold_bad;

  always @(posedge clk) begin
    cyc = cyc + 1;
    spi_rx_valid <= 1'b0;
    spi_tx_ready <= (cyc % 3) != 0;
    if (rst_n) begin
      if (prev_hold && (!spi_tx_valid || spi_tx_data != prev_data)) n_hold_bad++;
      if (spi_tx_valid && outstanding) n_hold_bad++;
      if (spi_rx_valid) outstanding = 1'b0;
      prev_hold = spi_tx_valid && !spi_tx_ready;
      prev_data = spi_tx_data;
      if (!cs_n[0]) cs_seen[0] = 1'b1;
      if (!cs_n[1]) cs_seen[1] = 1'b1;
      if (&cs_n && in_txn) begin
        in_txn = 1'b0;
        if ((op_m == 8'h02 || op_m == 8'h0A) && idx_m >= 2) begin
          n_bursts++;
          if (idx_m - 2 != 16) n_burst_bad++;
          wel[cur_dev] = 1'b0;
          wip_cnt = busy_polls;
        end
        if (op_m == 8'h01 && idx_m == 2) begin
          wel[cur_dev] = 1'b0;
          wip_cnt = busy_polls;
        end
        idx_m = 0;
      end
      if (!(&cs_n)) in_txn = 1'b1;
      if (spi_tx_valid && spi_tx_ready) begin
        b_m = spi_tx_data;
        resp_m = 8'hFF;
        d_m = (cs_n == 2'b10) ? 0 : ((cs_n == 2'b01) ? 1 : -1);
        if (d_m < 0) n_sel_err++;
        else if (idx_m == 0) begin
          op_m = b_m;
          cur_dev = d_m;
          if (b_m == 8'h06) begin wel[d_m] = 1'b1; n_wren++; end
        end else begin
          case (op_m)
            8'h01: begin
              if (idx_m == 1) begin
                n_wrsr++;
                if (!wel[d_m] || b_m != 8'h00) n_wrsr_bad++;
                sr[d_m] = b_m;
              end else n_proto_bad++;
            end
            8'h05: begin
              n_rdsr++;
              resp_m = {7'd0, wip_cnt > 0};
              if (wip_cnt > 0) wip_cnt--;
            end
            8'h02, 8'h0A: begin
              if (idx_m == 1) begin
                a_m = {op_m[3], b_m};
                if (op_m[3]) n_wr_hi++;
                if ((int'(a_m) - BASE) % 16 != 0) n_burst_bad++;
              end else begin
                if (!wel[d_m]) n_nowel++;
                mem[d_m][a_m] = b_m;
                a_m = a_m + 1'b1;
              end
            end
            8'h03, 8'h0B: begin
              if (idx_m == 1) begin
                a_m = {op_m[3], b_m};
                if (op_m[3]) n_rd_hi++;
              end else if (idx_m == 2) begin
                n_rd++;
                resp_m = mem[d_m][a_m] ^ ((int'(a_m) == corrupt) ? 8'h40 : 8'h00);
              end else n_proto_bad++;
            end
            default: n_proto_bad++;
          endcase
        end
        idx_m = idx_m + 1;
        outstanding = 1'b1;
        spi_rx_valid <= 1'b1;
        spi_rx_data  <= resp_m;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic prep(input int busy, input int bad_addr);
    @(negedge clk);
    busy_polls = busy; corrupt = bad_addr; wip_cnt = 0;
    n_wren = 0; n_wrsr = 0; n_wrsr_bad = 0; n_rdsr = 0; n_bursts = 0; n_burst_bad = 0;
    n_nowel = 0; n_wr_hi = 0; n_rd_hi = 0; n_rd = 0; n_sel_err = 0; n_proto_bad = 0;
    n_hold_bad = 0; cs_seen = 2'b00;
    for (int d = 0; d < 2; d++) begin
      wel[d] = 1'b0; sr[d] = 8'h0C;
      for (int a = 0; a < 512; a++) mem[d][a] = 8'hEE;
    end
  endtask

  // returns error level seen in the cycle done first appears
  task automatic run(input int dev, output bit err_at_done);
    int guard;
    @(negedge clk); dev_sel = 1'(dev); start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (!done && guard < 40000) begin @(negedge clk); guard++; end
    err_at_done = error;
    chk(done == 1'b1, "R10 done after pass", int'(done), 1);
  endtask

  function automatic int bad_cells(input int d);
    int n = 0;
    for (int a = BASE; a <= LAST; a++) if (mem[d][a] != 8'(a)) n++;
    return n;
  endfunction

  task automatic t_reset;
    chk(cs_n == 2'b11, "R1 selects high", int'(cs_n), 3);
    chk(!spi_tx_valid, "R1 no byte offered", int'(spi_tx_valid), 0);
    chk(!done && !error && !timed_out, "R1 flags clear", int'({done, error, timed_out}), 0);
  endtask

  task automatic t_clean;
    bit e;
    prep(2, -1);
    run(0, e);
    chk(!error && !timed_out, "R9 no error on clean pass", int'(error), 0);
    chk(n_wrsr == 1 && n_wrsr_bad == 0 && sr[0] == 8'h00, "R3 protection cleared", int'(sr[0]), 0);
    chk(n_wren == 8, "R3 R4 write-enable count", n_wren, 8);
    chk(n_bursts == 7 && n_burst_bad == 0, "R6 burst layout", n_bursts, 7);
    chk(n_nowel == 0, "R4 data written with enable set", n_nowel, 0);
    chk(bad_cells(0) == 0, "R4 pattern stored", bad_cells(0), 0);
    chk(n_wr_hi == 3, "R4 page bit in write opcode", n_wr_hi, 3);
    chk(n_rdsr == 24, "R5 busy polls repeated", n_rdsr, 24);
    chk(n_rd == NREG && n_rd_hi == 56, "R7 reads per address", n_rd, NREG);
    chk(n_rd_hi == 56, "R7 page bit in read opcode", n_rd_hi, 56);
    chk(n_sel_err == 0 && n_proto_bad == 0 && cs_seen == 2'b01, "R8 select framing", int'(cs_seen), 1);
    chk(n_hold_bad == 0, "R2 stream rules", n_hold_bad, 0);
    chk(progress == 9'(LAST), "R12 progress at end", int'(progress), LAST);
  endtask

  task automatic t_mismatch;
    bit e;
    prep(1, BASE + 37);
    run(0, e);
    chk(error == 1'b1, "R9 mismatch flagged", int'(error), 1);
    chk(fail_addr == 9'(BASE + 37), "R9 failing address", int'(fail_addr), BASE + 37);
    chk(n_rd == NREG, "R9 reading continues", n_rd, NREG);
  endtask

  task automatic t_last_byte;
    bit e;
    prep(0, LAST);
    run(0, e);
    chk(e == 1'b1, "R9 R10 error with done same cycle", int'(e), 1);
    chk(fail_addr == 9'(LAST), "R9 last address fails", int'(fail_addr), LAST);
  endtask

  task automatic t_timeout;
    bit e;
    prep(100, -1);
    run(0, e);
    chk(error && timed_out, "R11 abort flags", int'({error, timed_out}), 3);
    chk(n_rdsr == LIMIT, "R11 poll count at abort", n_rdsr, LIMIT);
    chk(n_bursts == 0, "R11 nothing after abort", n_bursts, 0);
  endtask

  task automatic t_dev1;
    bit e;
    prep(0, -1);
    run(1, e);
    chk(!error && !timed_out, "R10 restart clears flags", int'({error, timed_out}), 0);
    chk(cs_seen == 2'b10, "R8 only chosen device selected", int'(cs_seen), 2);
    chk(bad_cells(1) == 0, "R6 device 1 filled", bad_cells(1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_clean();
    t_mismatch();
    t_last_byte();
    t_timeout();
    t_dev1();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule